// File: doc/BRIEF.md
# Halt, Wake-Up and Reset-Status Controller

This block controls the low-power halt state of a small CPU core. A halt strobe from the instruction decoder moves it into a halted state in which the system oscillator is gated off. It stays there until a wake source appears: an external reset, a watchdog overflow, a new interrupt request, or a falling edge on an enabled port pin. After any wake-up the core is held in a stall for a fixed number of system clocks. When the stall ends, the controller either lets execution continue at the next instruction, asks the core to take an interrupt, or issues a warm reset that reinitialises only the program counter and stack pointer.

Two status flags record the halt and watchdog history, so that software can tell why the core is running again. The power-down flag shows that the core went through halt. The time-out flag shows that a watchdog overflow occurred. The watchdog counter itself and the CPU datapath are outside this block. The block only pulses a clear request to the watchdog when halt is entered.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While the active-low power-on reset `rst_n` is low, the controller sits in the running state. `pdf_o`, `to_o`, `osc_stop_o`, `stall_o`, `cold_rst_o`, `warm_rst_o` and `take_irq_o` are all 0.
- R2: A `halt_i` sampled high while running, with no external reset, has these effects.
  - `wdt_clr_o` is high combinationally in that cycle.
  - From the next cycle, `osc_stop_o`=1, `pdf_o`=1 and `to_o`=0.
  - `halt_i` has no effect while halted or stalled.
- R3: A `clr_wdt_i` sampled while running, with no halt strobe in the same cycle, clears `pdf_o` from the next cycle. If `halt_i` is high in the same cycle, the halt wins and `pdf_o` becomes 1.
- R4: Each `port_i` bit passes through a two-flop synchronizer and then a falling-edge detector. A fall on a pin whose `port_wake_en_i` bit is 1 wakes a halted controller: a pin driven low before edge k gives `stall_o`=1 after edge k+2. The wake resumes at the next instruction, with no `take_irq_o` pulse. A fall on a disabled pin has no effect.
- R5: Only an `irq_req_i` bit that was 0 when halt was entered wakes the controller. A bit that was already 1 at entry stays masked until it has dropped to 0 while halted.
- R6: A `wdt_ovf_i` while halted sets `to_o` from the next cycle, starts the stall, and ends it with a one-cycle `warm_rst_o` pulse. A `wdt_ovf_i` while running, with no halt strobe and no external reset, gives a one-cycle `cold_rst_o` pulse and sets `to_o`.
- R7: A wake-up starts the stall on the following cycle.
  - `osc_stop_o` drops and `stall_o` stays high for exactly STALL_CYCLES cycles (default 1024).
  - In the first cycle after the stall, the pending action is pulsed for one cycle.
- R8: On an interrupt wake, `take_irq_o` pulses after the stall only under two conditions, both sampled in the wake cycle.
  - At least one newly set request also has its `irq_en_i` bit set.
  - `stack_full_i` is 0.
  - Otherwise execution resumes with no pulse.
- R9: `ext_rst_i` is honoured in every state and gives a `cold_rst_o` pulse on the next cycle. It leaves `pdf_o` and `to_o` unchanged. When halted or stalled, it (re)starts a full stall that ends with no action pulse.
- R10: When several wake sources appear in one cycle, the wake priority is external reset, then watchdog overflow, then interrupt, then port pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst_i | input | 1 | External reset request, active high |
| halt_i | input | 1 | Halt instruction strobe |
| clr_wdt_i | input | 1 | Clear-watchdog instruction strobe |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| port_i | input | PORT_W | Asynchronous port pins |
| port_wake_en_i | input | PORT_W | Per-pin wake enable |
| irq_req_i | input | IRQ_W | Interrupt request flags |
| irq_en_i | input | IRQ_W | Interrupt enables |
| stack_full_i | input | 1 | Return stack is full |
| osc_stop_o | output | 1 | Gate the system oscillator (halted) |
| stall_o | output | 1 | Hold the core during the post-wake stall |
| cold_rst_o | output | 1 | Full device reset pulse |
| warm_rst_o | output | 1 | Program counter and stack pointer reset pulse |
| take_irq_o | output | 1 | Vector to the interrupt after the stall |
| wdt_clr_o | output | 1 | Clear the watchdog counter on halt entry |
| pdf_o | output | 1 | Power-down status flag |
| to_o | output | 1 | Time-out status flag |

## Verification
Two collisions matter here: a watchdog overflow and a fresh interrupt request arriving in the same halted cycle, and a halt strobe sharing a cycle with a clear-watchdog strobe. The bench drives both pairs on the same clock edge. For the first pair it expects a warm reset pulse with no interrupt vector at the end of the stall. For the second it expects the power-down flag to read 1. An external reset issued in the middle of a stall is also driven, and the bench judges it by requiring a complete fresh stall that ends with no action pulse. A behavioural model in the bench predicts every output on every clock for all of these cases.

// File: rtl/hwc_pkg.sv
// Shared types for the halt/wake controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package hwc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_STALL = 2'd2
    } hwc_state_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_RESUME = 2'd1,
        ACT_VECTOR = 2'd2,
        ACT_WARM   = 2'd3
    } hwc_act_t;
endpackage

// File: rtl/hwc_port_sync.sv
// Per-pin two-flop synchronizer followed by a falling-edge detector.
// Assumes pins are asynchronous to clk; flops reset to 0 so that no
// false fall is reported after reset.
module hwc_port_sync #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] wake_en_i,
    output logic [PORT_W-1:0] fall_o
);
    logic [PORT_W-1:0] meta_q;
    logic [PORT_W-1:0] sync_q;
    logic [PORT_W-1:0] prev_q;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        // Synchronize pin i and keep its previous synchronized value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= pin_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end

        // Report an enabled high-to-low transition.
        always_comb begin
            fall_o[i] = prev_q[i] & ~sync_q[i] & wake_en_i[i];
        end
    end
endmodule

// File: rtl/hwc_stall_timer.sv
// Post-wake stall timer: busy for exactly CYCLES clocks after start.
// A start while busy restarts the count. Assumes CYCLES >= 2.
module hwc_stall_timer #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Count stall cycles; start has priority over completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Flag the last busy cycle.
    always_comb begin
        busy_o = busy_q;
        done_o = busy_q && (cnt_q == LAST) && !start_i;
    end
endmodule

// File: rtl/hwc_wake_arb.sv
// Wake arbiter for the halted state. Priority: watchdog, interrupt, port.
// Picks the action to run once the stall completes. External reset is
// handled by the caller above this arbiter.
module hwc_wake_arb
    import hwc_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic             wdt_ovf_i,
    input  logic [IRQ_W-1:0] irq_req_i,
    input  logic [IRQ_W-1:0] irq_en_i,
    input  logic [IRQ_W-1:0] irq_mask_i,
    input  logic             stack_full_i,
    input  logic             port_fall_i,
    output logic             wake_o,
    output hwc_act_t         act_o
);
    logic [IRQ_W-1:0] fresh;

    // Choose the wake action by fixed priority.
    always_comb begin
        fresh  = irq_req_i & ~irq_mask_i;
        wake_o = 1'b1;
        act_o  = ACT_NONE;
        if (wdt_ovf_i) begin
            act_o = ACT_WARM;
        end else if (|fresh) begin
            act_o = ((|(fresh & irq_en_i)) && !stack_full_i) ? ACT_VECTOR : ACT_RESUME;
        end else if (port_fall_i) begin
            act_o = ACT_RESUME;
        end else begin
            wake_o = 1'b0;
        end
    end
endmodule

// File: rtl/halt_wake_ctrl.sv
// Halt, wake-up and reset-status controller (top).
// Sequences run -> halt -> stall -> run, keeps the power-down and
// time-out flags, and pulses the post-stall action. Assumes all strobes
// are synchronous to clk except port_i.
module halt_wake_ctrl
    import hwc_pkg::*;
#(
    parameter int PORT_W       = 8,
    parameter int IRQ_W        = 4,
    parameter int STALL_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_i,
    input  logic              halt_i,
    input  logic              clr_wdt_i,
    input  logic              wdt_ovf_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic [PORT_W-1:0] port_wake_en_i,
    input  logic [IRQ_W-1:0]  irq_req_i,
    input  logic [IRQ_W-1:0]  irq_en_i,
    input  logic              stack_full_i,
    output logic              osc_stop_o,
    output logic              stall_o,
    output logic              cold_rst_o,
    output logic              warm_rst_o,
    output logic              take_irq_o,
    output logic              wdt_clr_o,
    output logic              pdf_o,
    output logic              to_o
);
    hwc_state_t       state_q;
    hwc_act_t         act_q;
    hwc_act_t         arb_act;
    logic [IRQ_W-1:0] mask_q;
    logic [PORT_W-1:0] port_fall;
    logic             arb_wake;
    logic             timer_start;
    logic             timer_busy;
    logic             timer_done;
    logic             pdf_q, to_q;
    logic             cold_q, warm_q, take_q;

    hwc_port_sync #(.PORT_W(PORT_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (port_i),
        .wake_en_i (port_wake_en_i),
        .fall_o    (port_fall)
    );

    hwc_wake_arb #(.IRQ_W(IRQ_W)) u_arb (
        .wdt_ovf_i    (wdt_ovf_i),
        .irq_req_i    (irq_req_i),
        .irq_en_i     (irq_en_i),
        .irq_mask_i   (mask_q),
        .stack_full_i (stack_full_i),
        .port_fall_i  (|port_fall),
        .wake_o       (arb_wake),
        .act_o        (arb_act)
    );

    hwc_stall_timer #(.CYCLES(STALL_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (timer_start),
        .busy_o  (timer_busy),
        .done_o  (timer_done)
    );

    // Start the stall on a halted wake or on an external reset outside run.
    always_comb begin
        timer_start = ext_rst_i ? (state_q != ST_RUN)
                                : ((state_q == ST_HALT) && arb_wake);
    end

    // Main sequencer, status flags and one-cycle action pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            act_q   <= ACT_NONE;
            mask_q  <= '0;
            pdf_q   <= 1'b0;
            to_q    <= 1'b0;
            cold_q  <= 1'b0;
            warm_q  <= 1'b0;
            take_q  <= 1'b0;
        end else begin
            cold_q <= 1'b0;
            warm_q <= 1'b0;
            take_q <= 1'b0;
            if (ext_rst_i) begin
                cold_q <= 1'b1;
                if (state_q != ST_RUN) begin
                    state_q <= ST_STALL;
                    act_q   <= ACT_NONE;
                end
            end else begin
                unique case (state_q)
                    ST_RUN: begin
                        if (halt_i) begin
                            state_q <= ST_HALT;
                            pdf_q   <= 1'b1;
                            to_q    <= 1'b0;
                            mask_q  <= irq_req_i;
                        end else if (wdt_ovf_i) begin
                            cold_q <= 1'b1;
                            to_q   <= 1'b1;
                        end else if (clr_wdt_i) begin
                            pdf_q <= 1'b0;
                        end
                    end
                    ST_HALT: begin
                        mask_q <= mask_q & irq_req_i;
                        if (arb_wake) begin
                            state_q <= ST_STALL;
                            act_q   <= arb_act;
                            if (arb_act == ACT_WARM) begin
                                to_q <= 1'b1;
                            end
                        end
                    end
                    ST_STALL: begin
                        if (timer_done) begin
                            state_q <= ST_RUN;
                            warm_q  <= (act_q == ACT_WARM);
                            take_q  <= (act_q == ACT_VECTOR);
                            act_q   <= ACT_NONE;
                        end
                    end
                    default: state_q <= ST_RUN;
                endcase
            end
        end
    end

    // Drive the outputs from state and registers.
    always_comb begin
        osc_stop_o = (state_q == ST_HALT);
        stall_o    = timer_busy;
        cold_rst_o = cold_q;
        warm_rst_o = warm_q;
        take_irq_o = take_q;
        wdt_clr_o  = (state_q == ST_RUN) && halt_i && !ext_rst_i;
        pdf_o      = pdf_q;
        to_o       = to_q;
    end
endmodule

// File: rtl/halt_wake_ctrl_chk.sv
// Assertion checker for halt_wake_ctrl, attached by bind below.
// Observes ports only; keeps its own stall-length counter.
module halt_wake_ctrl_chk #(
    parameter int STALL_CYCLES = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic ext_rst_i,
    input logic osc_stop_o,
    input logic stall_o,
    input logic cold_rst_o,
    input logic warm_rst_o,
    input logic take_irq_o,
    input logic wdt_clr_o,
    input logic pdf_o,
    input logic to_o
);
    int unsigned run_len;

    // Track how many cycles the current stall has lasted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (ext_rst_i && (osc_stop_o || stall_o)) begin
            run_len <= 0;
        end else if (stall_o) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |=> (osc_stop_o && pdf_o && !to_o));  // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({osc_stop_o, stall_o}));  // R7
    AST_STALL_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(osc_stop_o));  // R7
    AST_STALL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_o) |-> (run_len == STALL_CYCLES));  // R7
    AST_WARM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_o |-> to_o);  // R6
    AST_VECTOR_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq_o |-> ($past(stall_o) && !stall_o));  // R8
    AST_COLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> cold_rst_o);  // R9
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({warm_rst_o, take_irq_o}));  // R10
endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk #(.STALL_CYCLES(STALL_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_rst_i  (ext_rst_i),
    .osc_stop_o (osc_stop_o),
    .stall_o    (stall_o),
    .cold_rst_o (cold_rst_o),
    .warm_rst_o (warm_rst_o),
    .take_irq_o (take_irq_o),
    .wdt_clr_o  (wdt_clr_o),
    .pdf_o      (pdf_o),
    .to_o       (to_o)
);

// File: tb/halt_wake_ctrl_test.sv
// Self-checking bench: a behavioural model predicts every output on
// every clock, plus directed checks at the scenario milestones.
module halt_wake_ctrl_test;
    localparam int PW = 8;
    localparam int IW = 4;
    localparam int NSTALL = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst = 1'b0, halt = 1'b0, clr_wdt = 1'b0, wdt_ovf = 1'b0;
    logic [PW-1:0] port = '1, wake_en = '0;
    logic [IW-1:0] irq_req = '0, irq_en = '0;
    logic stack_full = 1'b0;
    logic osc_stop, stall, cold_rst, warm_rst, take_irq, wdt_clr, pdf, to;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    halt_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst), .halt_i(halt),
        .clr_wdt_i(clr_wdt), .wdt_ovf_i(wdt_ovf), .port_i(port),
        .port_wake_en_i(wake_en), .irq_req_i(irq_req), .irq_en_i(irq_en),
        .stack_full_i(stack_full), .osc_stop_o(osc_stop), .stall_o(stall),
        .cold_rst_o(cold_rst), .warm_rst_o(warm_rst), .take_irq_o(take_irq),
        .wdt_clr_o(wdt_clr), .pdf_o(pdf), .to_o(to)
    );

    // Behavioural reference model: 0 run, 1 halted, 2 stalled.
    int m_st, m_cnt, m_act;   // act: 0 none, 1 resume, 2 vector, 3 warm
    bit m_pdf, m_to, m_cold, m_warm, m_take;
    logic [IW-1:0] m_mask;
    logic [PW-1:0] hist[$];

    always @(posedge clk) begin
        logic [PW-1:0] fall;
        logic [IW-1:0] fresh;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_act = 0; m_pdf = 0; m_to = 0;
            m_cold = 0; m_warm = 0; m_take = 0; m_mask = '0;
            hist = '{'0, '0, '0};
        end else begin
            fall = hist[2] & ~hist[1] & wake_en;
            m_cold = 0; m_warm = 0; m_take = 0;
            if (ext_rst) begin
                m_cold = 1;
                if (m_st != 0) begin m_st = 2; m_cnt = 0; m_act = 0; end
            end else if (m_st == 0) begin
                if (halt) begin m_st = 1; m_pdf = 1; m_to = 0; m_mask = irq_req; end
                else if (wdt_ovf) begin m_cold = 1; m_to = 1; end
                else if (clr_wdt) m_pdf = 0;
            end else if (m_st == 1) begin
                fresh = irq_req & ~m_mask;
                m_mask = m_mask & irq_req;
                if (wdt_ovf) begin m_st = 2; m_cnt = 0; m_act = 3; m_to = 1; end
                else if (fresh != 0) begin
                    m_st = 2; m_cnt = 0;
                    m_act = (((fresh & irq_en) != 0) && !stack_full) ? 2 : 1;
                end else if (fall != 0) begin m_st = 2; m_cnt = 0; m_act = 1; end
            end else begin
                if (m_cnt == NSTALL - 1) begin
                    m_st = 0; m_warm = (m_act == 3); m_take = (m_act == 2); m_act = 0;
                end else m_cnt++;
            end
            hist.push_front(port);
            void'(hist.pop_back());
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp(input logic a, input bit e, input string req);
        check(a === e, req, int'(a), int'(e));
    endtask

    // Compare every output against the model shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            cmp(osc_stop, m_st == 1, "R2 osc_stop");
            cmp(stall, m_st == 2, "R7 stall");
            cmp(cold_rst, m_cold, "R9 cold_rst");
            cmp(warm_rst, m_warm, "R6 warm_rst");
            cmp(take_irq, m_take, "R8 take_irq");
            cmp(wdt_clr, (m_st == 0) && halt && !ext_rst, "R2 wdt_clr");
            cmp(pdf, m_pdf, "R3 pdf");
            cmp(to, m_to, "R6 to");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_halt();
        halt = 1'b1; tick(1); halt = 1'b0;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #(4 * 100000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run hung)");
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        cmp(osc_stop, 0, "R1"); cmp(pdf, 0, "R1"); cmp(to, 0, "R1");
        cmp(cold_rst, 0, "R1"); cmp(stall, 0, "R1");
        rst_n = 1'b1; tick(3);

        // R4: enabled pin fall wakes; resume without vector.
        wake_en = 8'h01; pulse_halt(); tick(3);
        cmp(osc_stop, 1, "R2 halted"); cmp(pdf, 1, "R2 pdf set");
        port[0] = 1'b0; tick(3);
        cmp(stall, 1, "R4 pin wake");
        tick(NSTALL + 5); port[0] = 1'b1;
        cmp(stall, 0, "R7 stall over"); cmp(osc_stop, 0, "R7 running");

        // R4 disabled pin ignored; R8 enabled fresh irq vectors.
        tick(4); pulse_halt(); tick(2);
        port[1] = 1'b0; tick(10);
        cmp(osc_stop, 1, "R4 disabled pin ignored");
        irq_en = 4'h1; irq_req = 4'h1; tick(2);
        cmp(stall, 1, "R5 fresh irq wake");
        tick(NSTALL + 3); irq_req = '0; port[1] = 1'b1;

        // R3: clear-watchdog clears pdf.
        clr_wdt = 1'b1; tick(1); clr_wdt = 1'b0; tick(1);
        cmp(pdf, 0, "R3 pdf cleared");

        // R5 pending request masked; R8 stack full resumes.
        irq_req = 4'h2; tick(2); pulse_halt(); tick(20);
        cmp(osc_stop, 1, "R5 pending masked");
        irq_en = 4'h4; stack_full = 1'b1; irq_req = 4'h6; tick(2);
        cmp(stall, 1, "R5 new bit wakes");
        tick(NSTALL + 3); irq_req = '0; stack_full = 1'b0;

        // R8: disabled fresh irq wakes but resumes.
        pulse_halt(); tick(3); irq_req = 4'h8; tick(NSTALL + 4); irq_req = '0;

        // R6: watchdog overflow while halted -> warm reset.
        pulse_halt(); tick(3);
        wdt_ovf = 1'b1; tick(1); wdt_ovf = 1'b0;
        cmp(to, 1, "R6 to set");
        tick(NSTALL + 3);

        // R10: overflow and fresh irq collide -> warm wins.
        irq_en = 4'hF; pulse_halt(); tick(3);
        wdt_ovf = 1'b1; irq_req = 4'h1; tick(1); wdt_ovf = 1'b0;
        tick(NSTALL - 2);
        check(take_irq === 1'b0, "R10 no vector", int'(take_irq), 0);
        tick(5); irq_req = '0;

        // R6: overflow while running -> cold reset.
        clr_wdt = 1'b1; tick(1); clr_wdt = 1'b0;
        wdt_ovf = 1'b1; tick(1); wdt_ovf = 1'b0;
        cmp(to, 1, "R6 run overflow");

        // R3: halt and clear-watchdog together -> halt wins.
        halt = 1'b1; clr_wdt = 1'b1; tick(1); halt = 1'b0; clr_wdt = 1'b0;
        cmp(pdf, 1, "R3 halt wins");

        // R9: external reset in halt, then again mid-stall.
        tick(5); ext_rst = 1'b1; tick(1); ext_rst = 1'b0;
        cmp(stall, 1, "R9 stall after ext"); cmp(pdf, 1, "R9 flags kept");
        tick(500); ext_rst = 1'b1; tick(1); ext_rst = 1'b0;
        tick(NSTALL - 10);
        cmp(stall, 1, "R9 stall restarted");
        halt = 1'b1; tick(1); halt = 1'b0;
        tick(20);
        cmp(osc_stop, 0, "R2 halt ignored in stall");

        tick(5);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule